// File: doc/BRIEF.md
# Sampled Edge Count-Enable Generator

This block decides, cycle by cycle on the bus clock, whether a downstream timer may advance, and it conditions a bank of external inputs before they reach event logic. A two-bit mode code picks the timing source. The bus clock itself enables the timer on every cycle. Alternatively, a chosen edge of one chosen input, sampled on the bus clock, produces a one-cycle enable strobe. Or the chosen input, first brought through the full synchronizer and optionally inverted, becomes the timing source, with a strobe per rising edge of that conditioned level.

A single select code packs the input index and the edge polarity. In parallel, every input has its own synchronization enable: inputs with the bit set are seen through a two-flop synchronizer, the others pass straight through for the shortest response. When the upper mode bit is set, the synchronizer is always used for the selected input, whatever its enable bit says. Counting, prescaling and event matching belong to the consumer of these outputs.

Top module: `edge_clk_en`

## Requirements
- R1: With mode code 0 and reset low, `en_o` is 1 in every cycle.
- R2: With mode code 1, a selected edge on the raw input that is sampled at clock edge k makes `en_o` high for exactly the one cycle that follows edge k.
- R3: Select codes 0 to 7 choose input index code/2; an even code selects the rising edge and an odd code the falling edge; edges of the opposite polarity or on any other input give no strobe.
- R4: With mode code 2, the selected input passes through the two-stage synchronizer and is inverted for an odd code; a strobe appears for each rising edge of that level, two cycles later than the same edge in mode code 1.
- R5: Mode code 3 is reserved and `en_o` stays 0.
- R6: Select codes 8 to 15 are reserved; with mode code 1 or 2 they give no strobe.
- R7: For input i with `sync_mask_i[i]`=1, `cond_o[i]` equals the value `in_i[i]` had two clock edges earlier; with the bit 0 it follows `in_i[i]` in the same cycle.
- R8: With mode code 2 or 3 and a valid select code, the selected input's `cond_o` bit is synchronized even when its mask bit is 0; other inputs, and all inputs in modes 0 and 1, follow their own mask bit.
- R9: While `rst_i` is high `en_o` is 0 and the synchronizer stages hold 0, so every synchronized `cond_o` bit reads 0.
- R10: A pulse that spans a single sampling edge in mode code 1 gives exactly one strobe for its rising edge (even code) and exactly one for its falling edge (odd code).
- R11: After reset and after any change of mode or select code, no strobe is produced until two fresh samples of the new source exist, so a level that is already present never looks like an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Timing source: 0 bus clock, 1 sampled edge, 2 synchronized input, 3 reserved |
| sel_i | input | SEL_W | Bits above bit 0 give the input index, bit 0 picks falling (1) or rising (0) |
| sync_mask_i | input | NUM_IN | Per-input synchronizer enable, 1 = synchronize |
| in_i | input | NUM_IN | External inputs, asynchronous to the bus clock |
| cond_o | output | NUM_IN | Conditioned inputs for event logic |
| en_o | output | 1 | Count-enable strobe |

## Verification
The main function is driven with single pulses of several lengths on the selected line, on a neighbouring line, and under every mode and select class. A long pulse under rising and falling codes tells the two polarities apart by the cycle the strobe lands in. The same pulse in mode 1 and mode 2 measures the two-cycle synchronizer cost. One-cycle pulses show that the shortest legal pulse is still caught once. Pulses on unselected lines and under reserved codes must leave the strobe silent. A steady high level held across reset and across a select change separates a true edge from a stale sample.

// File: rtl/edge_clk_en_pkg.sv
package edge_clk_en_pkg;

    // widest select code the decode helper accepts
    localparam int unsigned CK_CODE_W = 8;

    typedef enum logic [1:0] {
        CK_BUS     = 2'd0,
        CK_SAMPLED = 2'd1,
        CK_INPUT   = 2'd2,
        CK_RSVD    = 2'd3
    } ck_mode_e;

    typedef struct packed {
        logic                 valid;
        logic                 falling;
        logic [CK_CODE_W-1:0] idx;
    } ck_sel_t;

    // split a select code into line index and polarity
    function automatic ck_sel_t decode_sel(input logic [CK_CODE_W-1:0] code,
                                           input int unsigned          nsrc);
        ck_sel_t d;
        d.valid   = (32'(code) < (nsrc << 1));
        d.falling = code[0];
        d.idx     = {1'b0, code[CK_CODE_W-1:1]};
        return d;
    endfunction

endpackage

// File: rtl/edge_clk_en_sync.sv
module edge_clk_en_sync #(
    parameter int unsigned NUM_IN = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_IN-1:0] in_i,
    input  logic [NUM_IN-1:0] sync_en_i,
    output logic [NUM_IN-1:0] synced_o,
    output logic [NUM_IN-1:0] cond_o
);

    logic [NUM_IN-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q[0] <= in_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign synced_o = chain_q[STAGES-1];

    // per-line choice between the synchronized copy and the raw pin
    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        assign cond_o[g] = sync_en_i[g] ? synced_o[g] : in_i[g];
    end

endmodule

// File: rtl/edge_clk_en_det.sv
module edge_clk_en_det #(
    parameter int unsigned FILL = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic src_i,
    output logic rise_o
);

    logic            src_q;
    logic            prev_q;
    logic [FILL-1:0] fill_q;

    // sample history: current sample and the one before it
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            src_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            src_q  <= src_i;
            prev_q <= src_q;
        end
    end

    // warm-up: both history slots must hold samples of the present source
    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            fill_q <= '0;
        end else begin
            fill_q <= (fill_q << 1) | FILL'(1);
        end
    end

    assign rise_o = fill_q[FILL-1] & src_q & ~prev_q;

endmodule

// File: rtl/edge_clk_en.sv
module edge_clk_en
    import edge_clk_en_pkg::*;
#(
    parameter int unsigned NUM_IN      = 8,
    parameter int unsigned NUM_SRC     = 4,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [NUM_IN-1:0] sync_mask_i,
    input  logic [NUM_IN-1:0] in_i,
    output logic [NUM_IN-1:0] cond_o,
    output logic              en_o
);

    localparam int unsigned IN_IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int unsigned CFG_W    = 2 + SEL_W;

    ck_mode_e              mode;
    ck_sel_t               dec;
    logic [IN_IDX_W-1:0]   pick;
    logic [NUM_IN-1:0]     force_sync;
    logic [NUM_IN-1:0]     sync_en;
    logic [NUM_IN-1:0]     synced;
    logic [CFG_W-1:0]      cfg_q;
    logic                  cfg_chg;
    logic                  src_pin;
    logic                  src;
    logic                  rise;

    assign mode = ck_mode_e'(mode_i);
    assign dec  = decode_sel(CK_CODE_W'(sel_i), NUM_SRC);
    assign pick = dec.idx[IN_IDX_W-1:0];

    // upper mode bit: the chosen line always goes through the synchronizer
    for (genvar g = 0; g < NUM_IN; g++) begin : g_force
        assign force_sync[g] = mode_i[1] & dec.valid & (dec.idx == CK_CODE_W'(g));
    end

    assign sync_en = sync_mask_i | force_sync;

    edge_clk_en_sync #(
        .NUM_IN (NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .in_i      (in_i),
        .sync_en_i (sync_en),
        .synced_o  (synced),
        .cond_o    (cond_o)
    );

    // configuration history to spot a change of source
    always_ff @(posedge clk_i) begin
        cfg_q <= {mode_i, sel_i};
    end

    assign cfg_chg = (cfg_q != {mode_i, sel_i});

    // one detector serves both edge modes: invert for falling, then look for a rise
    always_comb begin
        if (mode == CK_INPUT) begin
            src_pin = synced[pick];
        end else begin
            src_pin = in_i[pick];
        end
        src = src_pin ^ dec.falling;
    end

    edge_clk_en_det #(
        .FILL (2)
    ) u_det (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cfg_chg),
        .src_i  (src),
        .rise_o (rise)
    );

    always_comb begin
        en_o = 1'b0;
        if (!rst_i) begin
            case (mode)
                CK_BUS:     en_o = 1'b1;
                CK_SAMPLED: en_o = dec.valid & rise;
                CK_INPUT:   en_o = dec.valid & rise;
                default:    en_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/edge_clk_en_chk.sv
module edge_clk_en_chk #(
    parameter int unsigned NUM_IN      = 8,
    parameter int unsigned NUM_SRC     = 4,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [1:0]        mode_i,
    input logic [SEL_W-1:0]  sel_i,
    input logic [NUM_IN-1:0] sync_mask_i,
    input logic [NUM_IN-1:0] in_i,
    input logic [NUM_IN-1:0] cond_o,
    input logic              en_o
);

    logic [3:0] since_q;
    logic       pin_now;
    logic       sel_rsvd;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_q <= '0;
        end else if (since_q != 4'hF) begin
            since_q <= since_q + 4'd1;
        end
    end

    assign pin_now  = in_i[sel_i[SEL_W-1:1]] ^ sel_i[0];
    assign sel_rsvd = (32'(sel_i) >= (NUM_SRC << 1));

    // R1
    bus_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'd0) |-> en_o);

    // R5
    rsvd_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'd3) |-> !en_o);

    // R6
    rsvd_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i != 2'd0 && sel_rsvd) |-> !en_o);

    // R2
    one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_o && mode_i != 2'd0) |=> (!en_o || mode_i == 2'd0));

    // R3
    edge_pol_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_q > 4'd3 && mode_i == 2'd1 && $stable(mode_i) && $stable(sel_i) && en_o)
        |-> ($past(pin_now) && !$past(pin_now, 2)));

    // R7
    sync_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_q > 4'(SYNC_STAGES))
        |-> ((cond_o & sync_mask_i) == ($past(in_i, SYNC_STAGES) & sync_mask_i)));

endmodule

bind edge_clk_en edge_clk_en_chk #(
    .NUM_IN      (NUM_IN),
    .NUM_SRC     (NUM_SRC),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mode_i      (mode_i),
    .sel_i       (sel_i),
    .sync_mask_i (sync_mask_i),
    .in_i        (in_i),
    .cond_o      (cond_o),
    .en_o        (en_o)
);

// File: tb/edge_clk_en_bench.sv
`timescale 1ns/1ps
module edge_clk_en_bench;

    localparam int CLK_NS = 4;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] sel;
        logic [2:0] pin;
        logic [3:0] hold;
        logic [3:0] cnt;
        logic [3:0] first;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd0, 3'd0, 4'd3, 4'd8, 4'd1, 4'd1 },  // R1 every cycle
        '{2'd1, 4'd0, 3'd0, 4'd3, 4'd1, 4'd1, 4'd2 },  // R2 rise on line 0
        '{2'd1, 4'd1, 3'd0, 4'd3, 4'd1, 4'd4, 4'd3 },  // R3 fall on line 0
        '{2'd1, 4'd2, 3'd0, 4'd3, 4'd0, 4'd0, 4'd3 },  // R3 other line
        '{2'd1, 4'd2, 3'd1, 4'd3, 4'd1, 4'd1, 4'd3 },  // R3 line 1 rise
        '{2'd1, 4'd3, 3'd1, 4'd3, 4'd1, 4'd4, 4'd3 },  // R3 line 1 fall
        '{2'd1, 4'd7, 3'd3, 4'd1, 4'd1, 4'd2, 4'd10},  // R10 short pulse fall
        '{2'd1, 4'd6, 3'd3, 4'd1, 4'd1, 4'd1, 4'd10},  // R10 short pulse rise
        '{2'd2, 4'd4, 3'd2, 4'd3, 4'd1, 4'd3, 4'd4 },  // R4 synced rise
        '{2'd2, 4'd5, 3'd2, 4'd2, 4'd1, 4'd5, 4'd4 },  // R4 synced inverted
        '{2'd2, 4'd0, 3'd4, 4'd3, 4'd0, 4'd0, 4'd3 },  // R3 unselectable line
        '{2'd3, 4'd0, 3'd0, 4'd3, 4'd0, 4'd0, 4'd5 },  // R5 reserved mode
        '{2'd1, 4'd8, 3'd0, 4'd3, 4'd0, 4'd0, 4'd6 },  // R6 reserved code
        '{2'd2, 4'd9, 3'd4, 4'd3, 4'd0, 4'd0, 4'd6 }   // R6 reserved code
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic [3:0] sel;
    logic [7:0] mask;
    logic [7:0] pins;
    logic [7:0] cond;
    logic       en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    edge_clk_en u_edge_clk_en (
        .clk_i       (clk),
        .rst_i       (rst),
        .mode_i      (mode),
        .sel_i       (sel),
        .sync_mask_i (mask),
        .in_i        (pins),
        .cond_o      (cond),
        .en_o        (en)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        int first;

        // R9 reset state, R11 level held through reset
        rst = 1'b1; mode = 2'd0; sel = 4'd0; mask = 8'hFF; pins = 8'hFF;
        repeat (3) step();
        #1;
        check_eq("R9 en during reset", int'(en), 0);
        check_eq("R9 cond during reset", int'(cond), 0);
        step();
        mode = 2'd1; pins = 8'h01;
        step();
        rst = 1'b0;
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            step(); #1;
            if (en) cnt++;
        end
        check_eq("R11 no strobe after reset", cnt, 0);
        pins = 8'h00;
        repeat (4) step();

        // R7 synchronized versus bypassed lines
        mode = 2'd0; mask = 8'hBF; pins = 8'h00;
        repeat (4) step();
        pins = 8'h60;
        #1;
        check_eq("R7 bypass same cycle", int'(cond[6]), 1);
        check_eq("R7 synced not yet", int'(cond[5]), 0);
        step(); #1;
        check_eq("R7 synced after one edge", int'(cond[5]), 0);
        step(); #1;
        check_eq("R7 synced after two edges", int'(cond[5]), 1);

        // R8 forced synchronization of the chosen line in mode 2
        mode = 2'd2; sel = 4'd4; mask = 8'hBB; pins = 8'h00;
        repeat (4) step();
        pins = 8'h44;
        #1;
        check_eq("R8 chosen line forced sync", int'(cond[2]), 0);
        check_eq("R8 other line bypass", int'(cond[6]), 1);
        step(); #1;
        check_eq("R8 chosen line one edge", int'(cond[2]), 0);
        step(); #1;
        check_eq("R8 chosen line two edges", int'(cond[2]), 1);
        mode = 2'd1; pins = 8'h00;
        repeat (4) step();
        pins = 8'h04;
        #1;
        check_eq("R8 mode 1 keeps mask", int'(cond[2]), 1);
        pins = 8'h00;
        repeat (4) step();

        // R11 select change onto a line that is already high
        mode = 2'd1; sel = 4'd2; mask = 8'hFF; pins = 8'h01;
        repeat (4) step();
        sel = 4'd0;
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            #2;
            if (en) cnt++;
            step();
        end
        check_eq("R11 no strobe after select change", cnt, 0);
        pins = 8'h00;
        repeat (4) step();

        // vector table: R1 R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            mode = VECS[v].mode;
            sel  = VECS[v].sel;
            mask = 8'hFF;
            pins = 8'h00;
            repeat (4) step();
            pins[VECS[v].pin] = 1'b1;
            cnt   = 0;
            first = 0;
            for (int k = 1; k <= 8; k++) begin
                step();
                pins[VECS[v].pin] = (k < int'(VECS[v].hold));
                #2;
                if (en) begin
                    cnt++;
                    if (first == 0) first = k;
                end
            end
            check_eq($sformatf("R%0d vec%0d strobe count", VECS[v].req, v), cnt, int'(VECS[v].cnt));
            check_eq($sformatf("R%0d vec%0d strobe cycle", VECS[v].req, v), first, int'(VECS[v].first));
            pins = 8'h00;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule